// File: doc/BRIEF.md
# Match-Controlled 16-bit Timer

This block is a free-running 16-bit timer with four compare channels. A prescale counter divides the clock. Each time it wraps, the timer count advances by one. Each compare channel holds a 16-bit match value and three action bits. When the timer count equals a channel's match value on a prescale wrap, the channel can raise a sticky interrupt flag, return the timer count to zero, or halt the timer. The actions can be combined in any mix, on any channel.

Software reaches every register through a simple synchronous port. A write takes effect at the clock edge where the write enable is high. A read returns the addressed register one clock after the address is presented. The interrupt flags are cleared by writing ones to their positions. The interrupt line is the OR of all the flags. A halting match also clears the run bit, so software can see that the timer has stopped.

Top module: `match_timer16`

## Requirements
- R1: After reset, every register reads zero, `irq` and `irq_flags` are low, and the counters do not advance.
- R2: While the run bit is 1 and the hold bit is 0, the prescale counter steps 0,1,...,P and then wraps to 0, where P is the prescale register. The timer count increments by one on each wrap, so with P=1 it advances once every 2 clocks.
- R3: While the hold bit (control bit 1) is 1, the timer count and the prescale counter stay at zero, even with the run bit (control bit 0) set.
- R4: A channel matches on a prescale wrap when the timer count equals its match value. If the channel's interrupt action bit is set, its flag is set at that edge. If the bit is clear, the flag stays 0.
- R5: If a channel's reset action bit is set, the timer count goes to 0 at the match wrap instead of incrementing. The count never exceeds that match value, and the run bit stays 1.
- R6: If a channel's stop action bit is set, the run bit is cleared at the match wrap. The timer count holds the match value and the prescale counter is left at 0.
- R7: When several channels match on the same wrap, all their selected actions apply. Reset together with stop leaves the count at 0 and the run bit at 0.
- R8: Writing the flag register clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R9: `irq` is high exactly when at least one flag is set.
- R10: The action word holds three bits per channel at bits 3i (interrupt), 3i+1 (reset) and 3i+2 (stop) for channel i. Bits 31:12 read as 0.
- R11: The register map is: 0 control, 1 prescale, 2 action word, 3 flags, 4 timer count (read-only), 5 prescale counter (read-only), 8+i match value of channel i. Written values read back one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_flags | output | 4 | Sticky per-channel interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The hardest case to reach from the ports is several channels matching on the same prescale wrap with different actions. The stimulus sets up this case by giving three channels the same match value, each with a different action set, and then letting the timer run into that value. It then reads back the count, the run bit and the flags to check that all the actions took effect. Exact cycle timing is checked with the interrupt line, counted in edges from the write that starts the timer. Halting matches freeze the counters, so the final counter values can be read back without depending on the read latency.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ACT_W    = 3;
  localparam int ACT_IRQ  = 0;
  localparam int ACT_RST  = 1;
  localparam int ACT_STOP = 2;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_PRESC  = 4'd1;
  localparam logic [3:0] A_ACTION = 4'd2;
  localparam logic [3:0] A_FLAGS  = 4'd3;
  localparam logic [3:0] A_COUNT  = 4'd4;
  localparam logic [3:0] A_PCNT   = 4'd5;
  localparam logic [3:0] A_MATCH0 = 4'd8;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic [W-1:0] reload,
  output logic [W-1:0] pcount,
  output logic         tick
);
  assign tick = run && (pcount >= reload);

  always_ff @(posedge clk) begin
    if (rst || hold)
      pcount <= '0;
    else if (run)
      pcount <= tick ? '0 : pcount + 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pcount == '0));

  // R3
  hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (pcount == '0));
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
  import tmr16_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic [N-1:0][W-1:0]  match_val,
  input  logic [ACT_W*N-1:0]   action,
  input  logic [W-1:0]         count,
  input  logic                 tick,
  output logic [N-1:0]         hit,
  output logic [N-1:0]         flag_set,
  output logic                 do_reset,
  output logic                 do_stop
);
  logic [N-1:0] rst_req;
  logic [N-1:0] stop_req;

  for (genvar i = 0; i < N; i++) begin : g_chan
    assign hit[i]      = tick && (count == match_val[i]);
    assign flag_set[i] = hit[i] && action[ACT_W*i + ACT_IRQ];
    assign rst_req[i]  = hit[i] && action[ACT_W*i + ACT_RST];
    assign stop_req[i] = hit[i] && action[ACT_W*i + ACT_STOP];
  end

  assign do_reset = |rst_req;
  assign do_stop  = |stop_req;
endmodule

// File: rtl/match_timer16.sv
module match_timer16
  import tmr16_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int N_MATCH  = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_MATCH-1:0] irq_flags,
  output logic              irq
);
  localparam int ACTW_ALL = ACT_W * N_MATCH;

  logic                       run_bit;
  logic                       hold_bit;
  logic [CNT_W-1:0]           presc_q;
  logic [ACTW_ALL-1:0]        action_q;
  logic [N_MATCH-1:0][CNT_W-1:0] match_q;
  logic [N_MATCH-1:0]         flags_q;
  logic [CNT_W-1:0]           count_q;
  logic [CNT_W-1:0]           pcount;
  logic                       tick;
  logic [N_MATCH-1:0]         hit;
  logic [N_MATCH-1:0]         flag_set;
  logic                       do_reset;
  logic                       do_stop;
  logic                       run;
  logic [N_MATCH-1:0]         flag_clr;
  logic [DATA_W-1:0]          rd_next;

  assign run = run_bit && !hold_bit;

  tmr_prescaler #(.W(CNT_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .hold   (hold_bit),
    .reload (presc_q),
    .pcount (pcount),
    .tick   (tick)
  );

  tmr_match_bank #(.W(CNT_W), .N(N_MATCH)) u_bank (
    .match_val (match_q),
    .action    (action_q),
    .count     (count_q),
    .tick      (tick),
    .hit       (hit),
    .flag_set  (flag_set),
    .do_reset  (do_reset),
    .do_stop   (do_stop)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_bit <= 1'b0;
      presc_q  <= '0;
      action_q <= '0;
      match_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL)   hold_bit <= wdata[CTRL_HOLD];
      if (addr == A_PRESC)  presc_q  <= wdata[CNT_W-1:0];
      if (addr == A_ACTION) action_q <= wdata[ACTW_ALL-1:0];
      for (int i = 0; i < N_MATCH; i++)
        if (addr == A_MATCH0 + ADDR_W'(i)) match_q[i] <= wdata[CNT_W-1:0];
    end
  end

  // Run bit: a halting match overrides a software write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      run_bit <= 1'b0;
    else if (do_stop)
      run_bit <= 1'b0;
    else if (wr_en && addr == A_CTRL)
      run_bit <= wdata[CTRL_RUN];
  end

  // Timer count
  always_ff @(posedge clk) begin
    if (rst || hold_bit)
      count_q <= '0;
    else if (tick) begin
      if (do_reset)
        count_q <= '0;
      else if (!do_stop)
        count_q <= count_q + 1'b1;
    end
  end

  // Sticky flags, write-one-to-clear; a new match wins over a clear
  assign flag_clr = (wr_en && addr == A_FLAGS) ? wdata[N_MATCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else
      flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq_flags = flags_q;
  assign irq       = |flags_q;

  // Read path
  always_comb begin
    rd_next = '0;
    case (addr)
      A_CTRL:   begin
                  rd_next[CTRL_RUN]  = run_bit;
                  rd_next[CTRL_HOLD] = hold_bit;
                end
      A_PRESC:  rd_next[CNT_W-1:0]    = presc_q;
      A_ACTION: rd_next[ACTW_ALL-1:0] = action_q;
      A_FLAGS:  rd_next[N_MATCH-1:0]  = flags_q;
      A_COUNT:  rd_next[CNT_W-1:0]    = count_q;
      A_PCNT:   rd_next[CNT_W-1:0]    = pcount;
      default:  ;
    endcase
    for (int i = 0; i < N_MATCH; i++)
      if (addr == A_MATCH0 + ADDR_W'(i)) rd_next[CNT_W-1:0] = match_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R6
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    do_stop |=> !run_bit);

  // R6
  stop_freezes_count_chk: assert property (@(posedge clk) disable iff (rst)
    (do_stop && !do_reset && !hold_bit) |=> (count_q == $past(count_q)));

  // R5
  reset_match_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && do_reset) |=> (count_q == '0));

  // R3
  hold_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold_bit |=> (count_q == '0));

  // R4
  flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold_bit) |=> $stable(count_q));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (flags_q != '0));
endmodule

// File: tb/sim_match_timer16.sv
module sim_match_timer16;
  import tmr16_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq_flags;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  match_timer16 u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic zero_counters();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);
    check("R1", "flags after reset", {28'd0, irq_flags}, 32'd0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 32'd0);
    end
    repeat (10) @(posedge clk);
    rd(A_COUNT, v);
    check("R1", "count idle", v, 32'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_PRESC, 32'h0000_1234);
    rd(A_PRESC, v);
    check("R11", "prescale readback", v, 32'h1234);
    wr(A_ACTION, 32'hFFFF_FFFF);
    rd(A_ACTION, v);
    check("R10", "action upper bits zero", v, 32'h0000_0FFF);
    wr(A_ACTION, 32'h0);
    for (int i = 0; i < 4; i++) wr(A_MATCH0 + 4'(i), 32'h100 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      rd(A_MATCH0 + 4'(i), v);
      check("R11", $sformatf("match %0d readback", i), v, 32'h100 + 32'(i));
    end
  endtask

  // P=1, channel 0: interrupt + stop at 3 (bits 0 and 2)
  task automatic t_exact();
    logic [31:0] v;
    zero_counters();
    wr(A_PRESC, 32'd1);
    wr(A_MATCH0, 32'd3);
    wr(A_ACTION, 32'h5);
    wr(A_CTRL, 32'h1);
    repeat (7) @(posedge clk);
    @(negedge clk);
    check("R2", "no match before 8th edge", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R4", "irq at 8th edge", {31'd0, irq}, 32'd1);
    rd(A_COUNT, v);
    check("R6", "count holds match", v, 32'd3);
    rd(A_PCNT, v);
    check("R6", "prescale at zero", v, 32'd0);
    rd(A_CTRL, v);
    check("R6", "run bit cleared", v, 32'd0);
    wr(A_FLAGS, 32'h1);
    check("R8", "flag cleared", {28'd0, irq_flags}, 32'd0);
    check("R9", "irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  // P=3, channel 0: stop only at 4 (bit 2)
  task automatic t_presc_stop();
    logic [31:0] v;
    zero_counters();
    wr(A_PRESC, 32'd3);
    wr(A_MATCH0, 32'd4);
    wr(A_ACTION, 32'h4);
    wr(A_CTRL, 32'h1);
    repeat (40) @(posedge clk);
    rd(A_COUNT, v);
    check("R6", "count stopped at 4", v, 32'd4);
    rd(A_CTRL, v);
    check("R6", "run cleared", v, 32'd0);
    check("R4", "no flag with irq bit clear", {28'd0, irq_flags}, 32'd0);
  endtask

  // P=0: ch1 reset at 3 (bit 4), ch2 irq+stop at 7 (bits 6,8)
  task automatic t_reset_match();
    logic [31:0] v;
    zero_counters();
    wr(A_PRESC, 32'd0);
    wr(A_MATCH0 + 4'd1, 32'd3);
    wr(A_MATCH0 + 4'd2, 32'd7);
    wr(A_ACTION, 32'h150);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 12; k++) begin
      rd(A_COUNT, v);
      checks++;
      if (v > 32'd3) begin
        fails++;
        $display("FAIL R5 count bounded: actual=%0d expected<=3", v);
      end
    end
    rd(A_CTRL, v);
    check("R5", "still running", v, 32'd1);
    check("R5", "far match never reached", {28'd0, irq_flags}, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  // P=0, all at 3: ch0 irq+reset (0x3), ch1 stop (0x20), ch2 irq (0x40)
  task automatic t_combo();
    logic [31:0] v;
    zero_counters();
    for (int i = 0; i < 4; i++) wr(A_MATCH0 + 4'(i), 32'd3);
    wr(A_ACTION, 32'h63);
    wr(A_CTRL, 32'h1);
    repeat (20) @(posedge clk);
    rd(A_COUNT, v);
    check("R7", "count zero after reset+stop", v, 32'd0);
    rd(A_CTRL, v);
    check("R7", "run cleared", v, 32'd0);
    check("R7", "flags ch0 and ch2", {28'd0, irq_flags}, 32'h5);
    wr(A_FLAGS, 32'h1);
    check("R8", "only ch0 cleared", {28'd0, irq_flags}, 32'h4);
    check("R9", "irq still high", {31'd0, irq}, 32'd1);
    wr(A_FLAGS, 32'h4);
    check("R9", "irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(A_ACTION, 32'h0);
    wr(A_PRESC, 32'd0);
    wr(A_CTRL, 32'h3);
    repeat (10) @(posedge clk);
    rd(A_COUNT, v);
    check("R3", "count held", v, 32'd0);
    rd(A_PCNT, v);
    check("R3", "prescale held", v, 32'd0);
    wr(A_CTRL, 32'h1);
    repeat (5) @(posedge clk);
    rd(A_COUNT, v);
    check("R2", "count after 5 ticks with P=0", v, 32'd5);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_exact();
    t_presc_stop();
    t_reset_match();
    t_combo();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule